// File: doc/BRIEF.md
# Dual-Lane Fractional Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 32-bit processor's signal-processing extension. Each source operand carries two signed Q15 values packed side by side: the upper half (bits 31:16) and the lower half (bits 15:0). Every cycle the unit forms two 16x16 fractional products and folds their sum or difference into one of a small bank of 64-bit accumulators. The chosen accumulator is both the addend and the destination.

Three combining modes exist. The straight mode pairs upper with upper and lower with lower. The crossed mode pairs the upper half of A with the lower half of B, and the lower half of A with the upper half of B. The subtracting mode takes upper-times-upper minus lower-times-lower. A complex value stored as (real, imaginary) in the two halves therefore gets its real part from the subtracting mode and its imaginary part from the crossed mode. No instruction has to rotate an operand first. Accumulators are read back through a registered port, together with a sticky per-accumulator flag that records a saturated product.

Top module: `dual_frac_mac`

## Requirements
- R1: A synchronous active-high reset clears every accumulator, every overflow flag and `out_valid`. After reset, read-back returns zero for each accumulator and 0 for each flag.
- R2: Opcode 2'b00 adds P(A[31:16],B[31:16]) + P(A[15:0],B[15:0]) to the selected accumulator. P(x,y) is the signed 16x16 product shifted left by one and sign-extended to 64 bits.
- R3: Opcode 2'b01 adds P(A[31:16],B[15:0]) + P(A[15:0],B[31:16]) to the selected accumulator.
- R4: Opcode 2'b10 adds P(A[31:16],B[31:16]) - P(A[15:0],B[15:0]) to the selected accumulator.
- R5: When both inputs of a product are 16'h8000, that product is 32'h7FFFFFFF. Every other input pair gives the exact doubled product.
- R6: A per-accumulator overflow flag is set when either product of an operation saturates, and it stays set until reset. Flags of other accumulators are not affected.
- R7: An accepted operation raises `out_valid` exactly 3 cycles after it is presented. In that cycle `out_idx` is the selected accumulator and `out_acc` is its new value.
- R8: Operations may be issued every cycle, including back to back on the same accumulator, and no update is lost.
- R9: An operation with `in_valid` low or opcode 2'b11 changes no accumulator and no flag, and produces no `out_valid`.
- R10: Accumulators are independent. `rd_acc` and `rd_ovf` show the accumulator and flag selected by `rd_idx` one cycle after `rd_idx` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Mode: 00 straight, 01 crossed, 10 subtracting, 11 none |
| in_acc | input | IDX_W (2) | Accumulator selected as source and destination |
| in_a | input | 2*HALF_W (32) | Packed operand A |
| in_b | input | 2*HALF_W (32) | Packed operand B |
| out_valid | output | 1 | A result retires this cycle |
| out_idx | output | IDX_W (2) | Accumulator written by the retiring result |
| out_acc | output | ACC_W (64) | New value of that accumulator |
| rd_idx | input | IDX_W (2) | Read-back selector |
| rd_acc | output | ACC_W (64) | Registered read-back value |
| rd_ovf | output | 1 | Registered read-back of the sticky overflow flag |

## Verification
An operation presented before clock edge k retires after edge k+2. The bench keeps a three-entry history of what it issued, and at each falling edge it compares the outputs with the entry issued three falling edges earlier. Read-back trails `rd_idx` by one edge. Before reading, the bench issues three idle cycles so that every accepted operation has reached the accumulator storage. The expected accumulator values and flags are computed in the bench by integer arithmetic when each operation is issued, so bursts to one accumulator check the forwarding path cycle by cycle.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
  typedef enum logic [1:0] {
    OP_DOT   = 2'b00,
    OP_CROSS = 2'b01,
    OP_MSUB  = 2'b10,
    OP_NONE  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/dfm_lane_mul.sv
// One Q15 lane: doubled signed product, clamped for the single overflow pair.
module dfm_lane_mul #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0]   x,
  input  logic [HALF_W-1:0]   y,
  output logic [2*HALF_W-1:0] prod,
  output logic                sat
);
  localparam int PROD_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] MIN_IN  = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] MAX_OUT = {1'b0, {(PROD_W-1){1'b1}}};

  logic signed [PROD_W-1:0] raw;

  always_comb begin
    raw  = $signed(x) * $signed(y);
    sat  = (x == MIN_IN) && (y == MIN_IN);
    prod = sat ? MAX_OUT : (raw <<< 1);
  end
endmodule

// File: rtl/dfm_operand_route.sv
// Picks the half pairs that feed each lane for the requested mode.
module dfm_operand_route
  import dfm_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  mac_op_e                 op,
  input  logic [2*HALF_W-1:0]     a,
  input  logic [2*HALF_W-1:0]     b,
  output logic [1:0][HALF_W-1:0]  lx,
  output logic [1:0][HALF_W-1:0]  ly,
  output logic                    sub_lane1
);
  logic [HALF_W-1:0] a_hi, a_lo, b_hi, b_lo;

  always_comb begin
    a_hi = a[2*HALF_W-1:HALF_W];
    a_lo = a[HALF_W-1:0];
    b_hi = b[2*HALF_W-1:HALF_W];
    b_lo = b[HALF_W-1:0];
    lx[0] = a_hi;
    lx[1] = a_lo;
    sub_lane1 = 1'b0;
    if (op == OP_CROSS) begin
      ly[0] = b_lo;
      ly[1] = b_hi;
    end else begin
      ly[0] = b_hi;
      ly[1] = b_lo;
    end
    if (op == OP_MSUB) sub_lane1 = 1'b1;
  end
endmodule

// File: rtl/dfm_acc_bank.sv
// Accumulator storage: early pipeline read with one-level bypass,
// sticky overflow flags, registered read-back port.
module dfm_acc_bank #(
  parameter int NUM_ACC = 4,
  parameter int ACC_W   = 64,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] pipe_idx,
  output logic [ACC_W-1:0] pipe_base,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             wr_ovf,
  input  logic [IDX_W-1:0] host_idx,
  output logic [ACC_W-1:0] host_acc,
  output logic             host_ovf
);
  logic [ACC_W-1:0]   acc_q [NUM_ACC];
  logic [NUM_ACC-1:0] ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ACC; i++) acc_q[i] <= '0;
      ovf_q <= '0;
    end else if (wr_en) begin
      acc_q[wr_idx] <= wr_data;
      ovf_q[wr_idx] <= ovf_q[wr_idx] | wr_ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_base <= '0;
    end else if (wr_en && (wr_idx == pipe_idx)) begin
      pipe_base <= wr_data;
    end else begin
      pipe_base <= acc_q[pipe_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_acc <= '0;
      host_ovf <= 1'b0;
    end else begin
      host_acc <= acc_q[host_idx];
      host_ovf <= ovf_q[host_idx];
    end
  end
endmodule

// File: rtl/dual_frac_mac.sv
module dual_frac_mac
  import dfm_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int ACC_W   = 64,
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         in_op,
  input  logic [IDX_W-1:0]   in_acc,
  input  logic [2*HALF_W-1:0] in_a,
  input  logic [2*HALF_W-1:0] in_b,
  output logic               out_valid,
  output logic [IDX_W-1:0]   out_idx,
  output logic [ACC_W-1:0]   out_acc,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ACC_W-1:0]   rd_acc,
  output logic               rd_ovf
);
  localparam int OPND_W = 2 * HALF_W;
  localparam int PROD_W = 2 * HALF_W;
  localparam int LANES  = 2;
  localparam int EXT_W  = ACC_W - PROD_W;

  // stage 1: operand capture
  logic               s1_valid;
  mac_op_e            s1_op;
  logic [IDX_W-1:0]   s1_idx;
  logic [OPND_W-1:0]  s1_a, s1_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_NONE;
      s1_idx   <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
    end else begin
      s1_valid <= in_valid && (mac_op_e'(in_op) != OP_NONE);
      s1_op    <= mac_op_e'(in_op);
      s1_idx   <= in_acc;
      s1_a     <= in_a;
      s1_b     <= in_b;
    end
  end

  // lane routing and multipliers
  logic [LANES-1:0][HALF_W-1:0] lx, ly;
  logic [LANES-1:0][PROD_W-1:0] lp;
  logic [LANES-1:0]             lsat;
  logic                         sub1;

  dfm_operand_route #(.HALF_W(HALF_W)) u_route (
    .op(s1_op), .a(s1_a), .b(s1_b), .lx(lx), .ly(ly), .sub_lane1(sub1)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dfm_lane_mul #(.HALF_W(HALF_W)) u_mul (
      .x(lx[g]), .y(ly[g]), .prod(lp[g]), .sat(lsat[g])
    );
  end

  // stage 2: products registered, accumulator read in the bank
  logic                         s2_valid;
  logic [IDX_W-1:0]             s2_idx;
  logic [LANES-1:0][PROD_W-1:0] s2_p;
  logic                         s2_sat;
  logic                         s2_sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_idx   <= '0;
      s2_p     <= '0;
      s2_sat   <= 1'b0;
      s2_sub   <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      s2_idx   <= s1_idx;
      s2_p     <= lp;
      s2_sat   <= |lsat;
      s2_sub   <= sub1;
    end
  end

  // stage 3: combine and accumulate
  logic [ACC_W-1:0] s2_base, ext0, ext1, term, acc_new;

  always_comb begin
    ext0    = {{EXT_W{s2_p[0][PROD_W-1]}}, s2_p[0]};
    ext1    = {{EXT_W{s2_p[1][PROD_W-1]}}, s2_p[1]};
    term    = s2_sub ? (ext0 - ext1) : (ext0 + ext1);
    acc_new = s2_base + term;
  end

  dfm_acc_bank #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst),
    .pipe_idx(s1_idx), .pipe_base(s2_base),
    .wr_en(s2_valid), .wr_idx(s2_idx), .wr_data(acc_new), .wr_ovf(s2_sat),
    .host_idx(rd_idx), .host_acc(rd_acc), .host_ovf(rd_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_acc   <= '0;
    end else begin
      out_valid <= s2_valid;
      out_idx   <= s2_idx;
      out_acc   <= acc_new;
    end
  end
endmodule

// File: rtl/dfm_checker.sv
module dfm_checker #(
  parameter int HALF_W = 16,
  parameter int IDX_W  = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [1:0]          in_op,
  input logic [IDX_W-1:0]    in_acc,
  input logic                out_valid,
  input logic [IDX_W-1:0]    out_idx,
  input logic [IDX_W-1:0]    rd_idx,
  input logic                rd_ovf,
  input logic                s2_valid,
  input logic [4*HALF_W-1:0] s2_p
);
  localparam int PROD_W = 2 * HALF_W;
  localparam logic [PROD_W-1:0] MOST_NEG = {1'b1, {(PROD_W-1){1'b0}}};

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !rd_ovf));

  p_sat_r5: assert property (@(posedge clk) disable iff (rst)
    s2_valid |-> (s2_p[PROD_W-1:0] != MOST_NEG && s2_p[2*PROD_W-1:PROD_W] != MOST_NEG));

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_ovf && $stable(rd_idx)) |=> rd_ovf);

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op != 2'b11) |-> ##3 (out_valid && out_idx == $past(in_acc, 3)));

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || in_op == 2'b11) |-> ##3 !out_valid);
endmodule

bind dual_frac_mac dfm_checker #(.HALF_W(HALF_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_acc(in_acc),
  .out_valid(out_valid), .out_idx(out_idx), .rd_idx(rd_idx), .rd_ovf(rd_ovf),
  .s2_valid(s2_valid), .s2_p(s2_p)
);

// File: tb/dual_frac_mac_bench.sv
module dual_frac_mac_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b11;
  logic [1:0]  in_acc = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [1:0]  out_idx;
  logic [63:0] out_acc;
  logic [1:0]  rd_idx = '0;
  logic [63:0] rd_acc;
  logic        rd_ovf;

  dual_frac_mac u_dual_frac_mac (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_acc(in_acc),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_idx(out_idx),
    .out_acc(out_acc), .rd_idx(rd_idx), .rd_acc(rd_acc), .rd_ovf(rd_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  longint model [4];
  bit     ovf_m [4];
  bit     hv [3];
  logic [1:0] hi [3];
  longint hval [3];
  string  htag [3];
  logic [15:0] vals [8] = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000,
                            16'h0001, 16'h7FFF, 16'h4000, 16'hC000};

  function automatic longint fp(input logic [15:0] x, input logic [15:0] y);
    if (x == 16'h8000 && y == 16'h8000) return 64'sh7FFFFFFF;
    return longint'($signed(x)) * longint'($signed(y)) * 2;
  endfunction

  task automatic chk(input longint act, input longint exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 4; i++) begin model[i] = 0; ovf_m[i] = 0; end
    for (int i = 0; i < 3; i++) begin hv[i] = 0; hi[i] = 0; hval[i] = 0; htag[i] = "R9"; end
  endtask

  task automatic step(input bit v, input logic [1:0] op, input logic [1:0] idx,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    longint p0, p1;
    bit s;
    @(negedge clk);
    chk(longint'(out_valid), longint'(hv[2]), hv[2] ? "R7" : "R9", "out_valid");
    if (hv[2] && out_valid) begin
      chk(longint'(out_idx), longint'(hi[2]), "R7", "out_idx");
      chk(longint'(out_acc), hval[2], htag[2], "out_acc");
    end
    hv[2] = hv[1]; hi[2] = hi[1]; hval[2] = hval[1]; htag[2] = htag[1];
    hv[1] = hv[0]; hi[1] = hi[0]; hval[1] = hval[0]; htag[1] = htag[0];
    hv[0] = 0; htag[0] = "R9";
    if (v && op != 2'b11) begin
      if (op == 2'b01) begin
        p0 = fp(a[31:16], b[15:0]); p1 = fp(a[15:0], b[31:16]);
        s = (a[31:16] == 16'h8000 && b[15:0] == 16'h8000) || (a[15:0] == 16'h8000 && b[31:16] == 16'h8000);
      end else begin
        p0 = fp(a[31:16], b[31:16]); p1 = fp(a[15:0], b[15:0]);
        s = (a[31:16] == 16'h8000 && b[31:16] == 16'h8000) || (a[15:0] == 16'h8000 && b[15:0] == 16'h8000);
      end
      model[idx] = model[idx] + ((op == 2'b10) ? (p0 - p1) : (p0 + p1));
      ovf_m[idx] = ovf_m[idx] | s;
      hv[0] = 1; hi[0] = idx; hval[0] = model[idx]; htag[0] = tag;
    end
    in_valid = v; in_op = op; in_acc = idx; in_a = a; in_b = b;
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(0, 2'b00, 2'b00, 32'h0, 32'h0, "R9");
  endtask

  task automatic readback(input logic [1:0] idx, input string tag);
    rd_idx = idx;
    step(0, 2'b00, 2'b00, 32'h0, 32'h0, "R9");
    chk(longint'(rd_acc), model[idx], tag, "rd_acc");
    chk(longint'(rd_ovf), longint'(ovf_m[idx]), "R6", "rd_ovf");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    clear_model();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: state after reset
    chk(longint'(out_valid), 0, "R1", "out_valid after reset");
    for (int k = 0; k < 4; k++) readback(k[1:0], "R1");

    // R2 R3 R4 R5 R7 R8: sweep of half values, back to back, rotating accumulators
    for (int op = 0; op < 3; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          string t;
          t = (op == 0) ? "R2" : (op == 1) ? "R3" : "R4";
          if (vals[i] == 16'h8000 || vals[j] == 16'h8000) t = {t, "/R5"};
          step(1, op[1:0], 2'((i + j) % 4), {vals[i], vals[j]}, {vals[j], vals[i]}, t);
        end
        // R9: ignored slots between rows
        step(1, 2'b11, 2'(i % 4), 32'h80008000, 32'h80008000, "R9");
        step(0, 2'b00, 2'(i % 4), 32'h7FFF7FFF, 32'h7FFF7FFF, "R9");
      end
    end
    drain();
    for (int k = 0; k < 4; k++) readback(k[1:0], "R10");

    // R1: reset in the middle clears everything
    do_reset();
    for (int k = 0; k < 4; k++) readback(k[1:0], "R1");

    // R6: flag on one accumulator only, and sticky
    step(1, 2'b00, 2'd2, 32'h80000001, 32'h80000001, "R6");
    step(1, 2'b01, 2'd1, 32'h40002000, 32'h10007000, "R3");
    step(1, 2'b00, 2'd2, 32'h00010001, 32'h00020002, "R6");
    drain();
    for (int k = 0; k < 4; k++) readback(k[1:0], "R6");

    // R8: burst on one accumulator every cycle, mixed modes
    step(1, 2'b00, 2'd3, 32'h7FFF8001, 32'h7FFF7FFF, "R8");
    step(1, 2'b10, 2'd3, 32'h12345678, 32'h9ABCDEF0, "R8");
    step(1, 2'b01, 2'd3, 32'hC0004000, 32'h3000D000, "R8");
    step(1, 2'b10, 2'd3, 32'h80000001, 32'h7FFF8000, "R8");
    step(1, 2'b00, 2'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, "R8");
    step(1, 2'b01, 2'd0, 32'h00030005, 32'h00070009, "R10");
    drain();
    for (int k = 0; k < 4; k++) readback(k[1:0], "R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule